// File: doc/BRIEF.md
# Timing Error Recovery Controller

This controller sits beside an overclocked, out-of-order, two-wide processor pipeline whose critical registers may latch wrong data when the clock runs faster than the worst-case path. Each pipeline stage that can catch such a timing fault raises a flag. The monitored stages are fetch, decode, the four execution units and the reorder buffer. The controller captures the flags and, in the next cycle, issues the recovery controls that put the pipeline back into a correct state. These controls are holds, clears, a reorder-buffer invalidate mask, a commit block and a delay-register clear.

The recovery action depends on the stage that reported the fault. A fault always costs exactly one stall cycle of the whole pipeline. Faults reported in the same cycle by several stages merge into one recovery cycle that carries the union of their actions. An execution-unit fault also carries the reorder-buffer slot of the faulting instruction and a mask of the slots that depend on it. Together these name every entry to invalidate. The reorder buffer has five slots by default, and up to two instructions decode, issue and commit per cycle.

All inputs and outputs are plain control pins. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `tfr_ctrl`

## Requirements
- R1: Any fault flag sampled at a rising clock edge raises `pipe_stall` for exactly the one cycle that follows that edge.
- R2: A fetch fault raises `pc_hold` and `decode_clear` in the recovery cycle.
- R3: A decode fault raises `pc_hold`, `fetch_hold` and `rob_drop_newest` in the recovery cycle.
- R4: A fault on any bit of `err_fu` (bit 0 ALU, bit 1 multiply/divide, bit 2 load/store, bit 3 branch) raises `rs_stall`. It also drives `rob_inval` to `err_dep_mask` ORed with a one-hot word that has bit `err_rob_idx` set, both sampled with the fault.
- R5: When the fault slot index is ROB_DEPTH or larger (5, 6 or 7 by default), it adds no bit, and `rob_inval` equals the dependency mask alone.
- R6: A reorder-buffer fault raises `commit_block` and `dly_clr` in the recovery cycle.
- R7: Faults from several sources in the same cycle give the union of their actions, and the stall still lasts one cycle.
- R8: Without an execution-unit fault, `rob_inval` is zero and `rs_stall` is low, whatever `err_rob_idx` and `err_dep_mask` hold.
- R9: During reset, and in every cycle that follows a fault-free sample, all outputs are low.
- R10: Faults in consecutive cycles give consecutive recovery cycles, each with its own actions. The stall drops in the cycle after the last faulty sample has been handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_fetch | input | 1 | Fetch stage timing fault |
| err_decode | input | 1 | Decode stage timing fault |
| err_fu | input | NUM_FU | Per execution unit timing fault |
| err_rob | input | 1 | Reorder buffer timing fault |
| err_rob_idx | input | IDX_W | Reorder buffer slot of the faulting instruction |
| err_dep_mask | input | ROB_DEPTH | Slots that depend on the faulting instruction |
| pipe_stall | output | 1 | Whole-pipeline one-cycle stall |
| pc_hold | output | 1 | Hold the program counter |
| fetch_hold | output | 1 | Hold the fetch stage |
| decode_clear | output | 1 | Discard the decode stage contents |
| rs_stall | output | 1 | Stall the reservation stations |
| rob_drop_newest | output | 1 | Remove the youngest reorder buffer entry |
| rob_inval | output | ROB_DEPTH | Reorder buffer entries to invalidate |
| commit_block | output | 1 | Block commit this cycle |
| dly_clr | output | 1 | Clear the delay register |

## Verification
The block is first driven with isolated faults from each source, including every execution-unit bit and every slot index. This separates the per-stage action sets and shows that each unit is decoded independently. Slot indices 5 to 7 and dependency masks sent without a unit fault test the invalidate path's boundaries. Simultaneous multi-source faults tell a true union with a single stall apart from a lengthened or dropped action. Back-to-back faults and a long stretch of random flags test that every recovery cycle matches its own sample and does not leak into the next cycle.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

  // Which sources reported a fault in the captured cycle
  typedef struct packed {
    logic fetch;
    logic decode;
    logic fu;
    logic rob;
  } tfr_src_t;

  // Scalar recovery controls for one recovery cycle
  typedef struct packed {
    logic stall;
    logic pc_hold;
    logic fetch_hold;
    logic decode_clear;
    logic rs_stall;
    logic rob_drop_newest;
    logic commit_block;
    logic dly_clr;
  } tfr_act_t;

endpackage

// File: rtl/tfr_capture.sv
module tfr_capture
  import tfr_pkg::*;
#(
  parameter int ROB_DEPTH = 5,
  parameter int NUM_FU    = 4,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err_fetch,
  input  logic                 err_decode,
  input  logic [NUM_FU-1:0]    err_fu,
  input  logic                 err_rob,
  input  logic [IDX_W-1:0]     err_rob_idx,
  input  logic [ROB_DEPTH-1:0] err_dep_mask,
  output tfr_src_t             src_q,
  output logic [IDX_W-1:0]     idx_q,
  output logic [ROB_DEPTH-1:0] dep_q
);

  tfr_src_t src_d;

  always_comb begin
    src_d.fetch  = err_fetch;
    src_d.decode = err_decode;
    src_d.fu     = |err_fu;
    src_d.rob    = err_rob;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      idx_q <= '0;
      dep_q <= '0;
    end else begin
      src_q <= src_d;
      idx_q <= err_rob_idx;
      dep_q <= err_dep_mask;
    end
  end

endmodule

// File: rtl/tfr_action.sv
module tfr_action
  import tfr_pkg::*;
(
  input  tfr_src_t src,
  output tfr_act_t act
);

  always_comb begin
    act                 = '0;
    act.stall           = src.fetch | src.decode | src.fu | src.rob;
    act.pc_hold         = src.fetch | src.decode;
    act.decode_clear    = src.fetch;
    act.fetch_hold      = src.decode;
    act.rob_drop_newest = src.decode;
    act.rs_stall        = src.fu;
    act.commit_block    = src.rob;
    act.dly_clr         = src.rob;
  end

endmodule

// File: rtl/tfr_invmask.sv
module tfr_invmask #(
  parameter int ROB_DEPTH = 5,
  parameter int IDX_W     = 3
) (
  input  logic                 fu_fault,
  input  logic [IDX_W-1:0]     slot,
  input  logic [ROB_DEPTH-1:0] dep,
  output logic [ROB_DEPTH-1:0] inval
);

  for (genvar i = 0; i < ROB_DEPTH; i++) begin : g_slot
    logic hit;
    assign hit      = (slot == IDX_W'(i));
    assign inval[i] = fu_fault & (dep[i] | hit);
  end

endmodule

// File: rtl/tfr_ctrl.sv
module tfr_ctrl
  import tfr_pkg::*;
#(
  parameter int ROB_DEPTH = 5,
  parameter int NUM_FU    = 4,
  localparam int IDX_W    = (ROB_DEPTH > 1) ? $clog2(ROB_DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err_fetch,
  input  logic                 err_decode,
  input  logic [NUM_FU-1:0]    err_fu,
  input  logic                 err_rob,
  input  logic [IDX_W-1:0]     err_rob_idx,
  input  logic [ROB_DEPTH-1:0] err_dep_mask,
  output logic                 pipe_stall,
  output logic                 pc_hold,
  output logic                 fetch_hold,
  output logic                 decode_clear,
  output logic                 rs_stall,
  output logic                 rob_drop_newest,
  output logic [ROB_DEPTH-1:0] rob_inval,
  output logic                 commit_block,
  output logic                 dly_clr
);

  tfr_src_t             src_q;
  tfr_act_t             act;
  logic [IDX_W-1:0]     idx_q;
  logic [ROB_DEPTH-1:0] dep_q;

  tfr_capture #(
    .ROB_DEPTH(ROB_DEPTH),
    .NUM_FU   (NUM_FU),
    .IDX_W    (IDX_W)
  ) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_fetch   (err_fetch),
    .err_decode  (err_decode),
    .err_fu      (err_fu),
    .err_rob     (err_rob),
    .err_rob_idx (err_rob_idx),
    .err_dep_mask(err_dep_mask),
    .src_q       (src_q),
    .idx_q       (idx_q),
    .dep_q       (dep_q)
  );

  tfr_action u_action (
    .src(src_q),
    .act(act)
  );

  tfr_invmask #(
    .ROB_DEPTH(ROB_DEPTH),
    .IDX_W    (IDX_W)
  ) u_invmask (
    .fu_fault(src_q.fu),
    .slot    (idx_q),
    .dep     (dep_q),
    .inval   (rob_inval)
  );

  assign pipe_stall      = act.stall;
  assign pc_hold         = act.pc_hold;
  assign fetch_hold      = act.fetch_hold;
  assign decode_clear    = act.decode_clear;
  assign rs_stall        = act.rs_stall;
  assign rob_drop_newest = act.rob_drop_newest;
  assign commit_block    = act.commit_block;
  assign dly_clr         = act.dly_clr;

endmodule

// File: rtl/tfr_ctrl_chk.sv
module tfr_ctrl_chk #(
  parameter int ROB_DEPTH = 5,
  parameter int NUM_FU    = 4,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 err_fetch,
  input logic                 err_decode,
  input logic [NUM_FU-1:0]    err_fu,
  input logic                 err_rob,
  input logic [IDX_W-1:0]     err_rob_idx,
  input logic [ROB_DEPTH-1:0] err_dep_mask,
  input logic                 pipe_stall,
  input logic                 pc_hold,
  input logic                 fetch_hold,
  input logic                 decode_clear,
  input logic                 rs_stall,
  input logic                 rob_drop_newest,
  input logic [ROB_DEPTH-1:0] rob_inval,
  input logic                 commit_block,
  input logic                 dly_clr
);

  function automatic logic [ROB_DEPTH-1:0] slot_bit(input logic [IDX_W-1:0] s);
    logic [ROB_DEPTH-1:0] r;
    r = '0;
    for (int k = 0; k < ROB_DEPTH; k++) begin
      if (int'(s) == k) r[k] = 1'b1;
    end
    return r;
  endfunction

  logic any_err;
  assign any_err = err_fetch | err_decode | (|err_fu) | err_rob;

  a_r1_stall_follows: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |=> pipe_stall);

  a_r2_fetch_actions: assert property (@(posedge clk) disable iff (!rst_n)
    err_fetch |=> (pc_hold && decode_clear));

  a_r3_decode_actions: assert property (@(posedge clk) disable iff (!rst_n)
    err_decode |=> (pc_hold && fetch_hold && rob_drop_newest));

  a_r4_fu_inval: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_fu) |=> (rs_stall &&
      rob_inval == ($past(err_dep_mask) | slot_bit($past(err_rob_idx)))));

  a_r6_rob_actions: assert property (@(posedge clk) disable iff (!rst_n)
    err_rob |=> (commit_block && dly_clr));

  a_r8_no_fu_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|err_fu) |=> (rob_inval == '0 && !rs_stall));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !any_err |=> !(pipe_stall || pc_hold || fetch_hold || decode_clear ||
                   commit_block || dly_clr || rob_drop_newest));

  a_r3_fetch_hold_only_decode: assert property (@(posedge clk) disable iff (!rst_n)
    !err_decode |=> !fetch_hold);

  a_r1_actions_imply_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_hold || rs_stall || commit_block || $countones(rob_inval) != 0) |-> pipe_stall);

endmodule

bind tfr_ctrl tfr_ctrl_chk #(
  .ROB_DEPTH(ROB_DEPTH),
  .NUM_FU   (NUM_FU),
  .IDX_W    (IDX_W)
) u_chk (.*);

// File: tb/tfr_ctrl_bench.sv
module tfr_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ROB_DEPTH  = 5;
  localparam int NUM_FU     = 4;
  localparam int IDX_W      = 3;
  localparam int WATCHDOG   = 100000;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 err_fetch = 1'b0;
  logic                 err_decode = 1'b0;
  logic [NUM_FU-1:0]    err_fu = '0;
  logic                 err_rob = 1'b0;
  logic [IDX_W-1:0]     err_rob_idx = '0;
  logic [ROB_DEPTH-1:0] err_dep_mask = '0;
  logic                 pipe_stall, pc_hold, fetch_hold, decode_clear;
  logic                 rs_stall, rob_drop_newest, commit_block, dly_clr;
  logic [ROB_DEPTH-1:0] rob_inval;

  tfr_ctrl #(.ROB_DEPTH(ROB_DEPTH), .NUM_FU(NUM_FU)) u_tfr_ctrl (
    .clk(clk), .rst_n(rst_n),
    .err_fetch(err_fetch), .err_decode(err_decode), .err_fu(err_fu),
    .err_rob(err_rob), .err_rob_idx(err_rob_idx), .err_dep_mask(err_dep_mask),
    .pipe_stall(pipe_stall), .pc_hold(pc_hold), .fetch_hold(fetch_hold),
    .decode_clear(decode_clear), .rs_stall(rs_stall),
    .rob_drop_newest(rob_drop_newest), .rob_inval(rob_inval),
    .commit_block(commit_block), .dly_clr(dly_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  // Inputs seen at the last rising edge (reference model state)
  bit               p_fetch, p_decode, p_rob, p_any2;
  bit [NUM_FU-1:0]  p_fu;
  int               p_idx;
  bit [ROB_DEPTH-1:0] p_dep;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare the outputs with what the previous sample demands
  task automatic compare_all();
    int nsrc;
    bit any, fu;
    bit [ROB_DEPTH-1:0] inv;
    string ts, ti;
    fu   = (p_fu != 0);
    any  = p_fetch | p_decode | fu | p_rob;
    nsrc = int'(p_fetch) + int'(p_decode) + int'(fu) + int'(p_rob);
    inv  = '0;
    for (int k = 0; k < ROB_DEPTH; k++)
      if (fu && (p_dep[k] || p_idx == k)) inv[k] = 1'b1;
    if (!any)           ts = "R9";
    else if (nsrc > 1)  ts = "R7";
    else if (p_any2)    ts = "R10";
    else                ts = "R1";
    if (!fu)                   ti = "R8";
    else if (p_idx >= ROB_DEPTH) ti = "R5";
    else                       ti = "R4";
    chk(ts, "pipe_stall", int'(pipe_stall), int'(any));
    chk(any ? "R2" : "R9", "pc_hold", int'(pc_hold), int'(p_fetch | p_decode));
    chk(any ? "R2" : "R9", "decode_clear", int'(decode_clear), int'(p_fetch));
    chk(any ? "R3" : "R9", "fetch_hold", int'(fetch_hold), int'(p_decode));
    chk(any ? "R3" : "R9", "rob_drop_newest", int'(rob_drop_newest), int'(p_decode));
    chk(fu ? "R4" : "R8", "rs_stall", int'(rs_stall), int'(fu));
    chk(ti, "rob_inval", int'(rob_inval), int'(inv));
    chk(any ? "R6" : "R9", "commit_block", int'(commit_block), int'(p_rob));
    chk(any ? "R6" : "R9", "dly_clr", int'(dly_clr), int'(p_rob));
    p_any2 = any;
  endtask

  // Called at a falling edge: check, then drive the next sample
  task automatic step(input bit f, input bit d, input bit [NUM_FU-1:0] u,
                      input bit r, input int idx, input bit [ROB_DEPTH-1:0] dep);
    compare_all();
    err_fetch    = f;
    err_decode   = d;
    err_fu       = u;
    err_rob      = r;
    err_rob_idx  = IDX_W'(idx);
    err_dep_mask = dep;
    p_fetch = f; p_decode = d; p_fu = u; p_rob = r; p_idx = idx; p_dep = dep;
    @(negedge clk);
  endtask

  initial begin
    p_fetch = 0; p_decode = 0; p_rob = 0; p_any2 = 0; p_fu = '0; p_idx = 0; p_dep = '0;
    // R9: reset state, with faults applied while reset is held
    @(negedge clk);
    err_fetch = 1'b1; err_fu = 4'b1111; err_rob = 1'b1; err_dep_mask = '1;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "reset pipe_stall", int'(pipe_stall), 0);
    chk("R9", "reset rob_inval", int'(rob_inval), 0);
    chk("R9", "reset commit_block", int'(commit_block), 0);
    chk("R9", "reset pc_hold", int'(pc_hold), 0);
    err_fetch = 1'b0; err_fu = '0; err_rob = 1'b0; err_dep_mask = '0;
    rst_n = 1'b1;
    @(negedge clk);

    step(0, 0, 4'b0000, 0, 0, 5'b00000);
    // R2 isolated fetch fault
    step(1, 0, 4'b0000, 0, 0, 5'b00000);
    step(0, 0, 4'b0000, 0, 0, 5'b00000);
    // R3 isolated decode fault
    step(0, 1, 4'b0000, 0, 0, 5'b00000);
    step(0, 0, 4'b0000, 0, 0, 5'b00000);
    // R4 each execution unit, every valid slot
    for (int u = 0; u < NUM_FU; u++) begin
      for (int s = 0; s < ROB_DEPTH; s++) begin
        step(0, 0, 4'(1 << u), 0, s, 5'(s * 3 + u));
        step(0, 0, 4'b0000, 0, 0, 5'b00000);
      end
    end
    // R5 out-of-range slot indices
    for (int s = ROB_DEPTH; s < 8; s++) begin
      step(0, 0, 4'b0010, 0, s, 5'b10100);
      step(0, 0, 4'b0001, 0, s, 5'b00000);
      step(0, 0, 4'b0000, 0, 0, 5'b00000);
    end
    // R6 reorder buffer fault
    step(0, 0, 4'b0000, 1, 0, 5'b00000);
    step(0, 0, 4'b0000, 0, 0, 5'b00000);
    // R8 index and mask without a unit fault
    step(0, 0, 4'b0000, 0, 3, 5'b11111);
    step(1, 0, 4'b0000, 1, 2, 5'b01010);
    step(0, 0, 4'b0000, 0, 0, 5'b00000);
    // R7 simultaneous sources
    step(1, 1, 4'b1000, 1, 4, 5'b00011);
    step(0, 0, 4'b0000, 0, 0, 5'b00000);
    step(1, 0, 4'b0100, 0, 0, 5'b00000);
    step(0, 1, 4'b0000, 1, 0, 5'b00000);
    step(0, 0, 4'b0000, 0, 0, 5'b00000);
    // R10 back-to-back faults with changing actions
    step(1, 0, 4'b0000, 0, 0, 5'b00000);
    step(0, 1, 4'b0000, 0, 0, 5'b00000);
    step(0, 0, 4'b0001, 0, 1, 5'b10000);
    step(0, 0, 4'b0100, 0, 2, 5'b00001);
    step(0, 0, 4'b0000, 1, 0, 5'b00000);
    step(0, 0, 4'b0000, 0, 0, 5'b00000);
    step(0, 0, 4'b0000, 0, 0, 5'b00000);
    // Random flags
    for (int n = 0; n < 400; n++) begin
      bit [31:0] rv;
      rv = $urandom;
      step(rv[0] & rv[1], rv[2] & rv[3], rv[7:4] & rv[11:8], rv[12] & rv[13],
           int'(rv[16:14]), rv[21:17]);
    end
    step(0, 0, 4'b0000, 0, 0, 5'b00000);
    compare_all();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule